// File: doc/BRIEF.md
# Watchdog Timer with Single or Paired Clear

This block is a watchdog counter for a microcontroller-class chip. It advances on tick enables taken from one of three clock sources and raises a one-cycle time-out pulse when it wraps. Firmware keeps the pulse from firing by clearing the counter through two separate clear strobes. Each strobe stands for a distinct clear instruction.

Three static straps configure the block. One strap turns the watchdog on or off. One picks the tick source. One picks the clear discipline. In single mode either strobe restarts the counter. In paired mode the counter restarts only once both strobes have been seen, in either order. This makes it less likely that one stray instruction keeps a runaway program alive. The straps are meant to change only while reset is held. The time-out pulse is used by the surrounding chip to start its reset sequence.

Top module: `wdg_timer`

## Requirements
- R1: After the synchronous reset, `timeout_o` is 0 and the counter starts from zero, so the first pulse comes on exactly the 2^CNT_W-th selected tick.
- R2: `src_sel_i` picks the tick source: 0 selects `tick_sys4_i`, 1 selects `tick_rtc_i`, 2 selects `tick_osc_i`, and 3 selects no source. Ticks on sources that are not selected do not advance the counter.
- R3: `timeout_o` is high for exactly one cycle. This happens on the cycle after the selected tick that moves the counter past its all-ones value. The counter then restarts from zero, so pulses repeat every 2^CNT_W ticks.
- R4: With `wdg_en_i` low, the counter holds at zero and `timeout_o` never rises.
- R5: With `dual_clr_i` low, a single `clr_a_i` or `clr_b_i` strobe clears the counter.
- R6: With `dual_clr_i` high, one strobe alone does not clear the counter. The counter clears on the cycle that completes the pair `clr_a_i` and `clr_b_i`. The pair may arrive in either order or in the same cycle.
- R7: In paired mode, repeating the same strobe adds nothing. Both pending marks drop when the counter clears, so a later lone strobe does not clear it.
- R8: A clear in the same cycle as a selected tick wins: the counter goes to zero and that tick is lost.
- R9: Reset drops both pending clear marks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wdg_en_i | input | 1 | Static strap: watchdog on |
| dual_clr_i | input | 1 | Static strap: 1 = paired clear, 0 = single clear |
| src_sel_i | input | 2 | Static strap: tick source (0 sys/4, 1 RTC, 2 watchdog osc, 3 none) |
| tick_sys4_i | input | 1 | Tick enable from system clock / 4 |
| tick_rtc_i | input | 1 | Tick enable from the real-time oscillator |
| tick_osc_i | input | 1 | Tick enable from the dedicated watchdog oscillator |
| clr_a_i | input | 1 | First clear strobe |
| clr_b_i | input | 1 | Second clear strobe |
| timeout_o | output | 1 | One-cycle time-out pulse (registered) |

## Verification
The only output is the time-out pulse, so a faulty count or a faulty pending mark shows up as a pulse that comes early, late, or not at all. Such a fault is visible no later than one full period of 2^CNT_W ticks after the wrong state appears.

The bench measures pulse timing against tick counts that it computes itself. A wrongly kept or wrongly lost pending mark moves the next pulse by the number of ticks since the intended clear. A source-select fault makes pulses appear from an idle line or disappear from the chosen one. To keep runs short, the bench uses a narrow counter.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [1:0] {
    SRC_SYS4 = 2'd0,
    SRC_RTC  = 2'd1,
    SRC_OSC  = 2'd2,
    SRC_NONE = 2'd3
  } wdg_src_e;
  localparam int unsigned NUM_CLR = 2;
endpackage

// File: rtl/wdg_tick_sel.sv
module wdg_tick_sel
  import wdg_pkg::*;
(
  input  logic     [1:0] src_sel_i,
  input  logic           tick_sys4_i,
  input  logic           tick_rtc_i,
  input  logic           tick_osc_i,
  output logic           tick_o
);
  wdg_src_e src;
  always_comb begin
    src = wdg_src_e'(src_sel_i);
    unique case (src)
      SRC_SYS4: tick_o = tick_sys4_i;
      SRC_RTC:  tick_o = tick_rtc_i;
      SRC_OSC:  tick_o = tick_osc_i;
      default:  tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/wdg_clear_ctl.sv
module wdg_clear_ctl
  import wdg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic dual_i,
  input  logic clr_a_i,
  input  logic clr_b_i,
  output logic clr_now_o
);
  logic [NUM_CLR-1:0] strobe;
  logic [NUM_CLR-1:0] pend_q;
  logic [NUM_CLR-1:0] seen;

  assign strobe = {clr_b_i, clr_a_i};
  assign seen   = pend_q | strobe;

  always_comb begin
    if (!en_i)       clr_now_o = 1'b0;
    else if (dual_i) clr_now_o = (&seen) && (|strobe);
    else             clr_now_o = |strobe;
  end

  for (genvar g = 0; g < NUM_CLR; g++) begin : g_pend
    always_ff @(posedge clk_i) begin
      if (rst_i || !en_i || !dual_i || clr_now_o) pend_q[g] <= 1'b0;
      else if (strobe[g])                         pend_q[g] <= 1'b1;
    end
  end

  // R7: marks drop once a clear has taken effect
  a_r7_marks_drop: assert property (@(posedge clk_i) disable iff (rst_i)
    clr_now_o |=> (pend_q == '0));
  // R9: reset leaves no pending mark
  a_r9_reset_marks: assert property (@(posedge clk_i)
    rst_i |=> (pend_q == '0));
  // R6: a lone first strobe with nothing pending does not clear
  a_r6_lone_no_clear: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && dual_i && pend_q == '0 && (clr_a_i ^ clr_b_i)) |-> !clr_now_o);
  // R6: a lone strobe is remembered for the next one
  a_r6_mark_kept: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && dual_i && clr_a_i && !clr_now_o) |=> pend_q[0]);
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic tick_i,
  input  logic clr_i,
  output logic timeout_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             to_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else begin
      to_q <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (cnt_q == CNT_MAX) begin
          cnt_q <= '0;
          to_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign timeout_o = to_q;

  // R3: the pulse never lasts two cycles
  a_r3_pulse_single: assert property (@(posedge clk_i) disable iff (rst_i)
    to_q |=> !to_q);
  // R4: switched off means parked at zero
  a_r4_off_idle: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> (cnt_q == '0 && !to_q));
  // R8: a clear beats a tick in the same cycle
  a_r8_clear_wins: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && clr_i) |=> (cnt_q == '0 && !to_q));
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       wdg_en_i,
  input  logic       dual_clr_i,
  input  logic [1:0] src_sel_i,
  input  logic       tick_sys4_i,
  input  logic       tick_rtc_i,
  input  logic       tick_osc_i,
  input  logic       clr_a_i,
  input  logic       clr_b_i,
  output logic       timeout_o
);
  logic tick_w;
  logic clr_now_w;

  wdg_tick_sel u_sel (
    .src_sel_i   (src_sel_i),
    .tick_sys4_i (tick_sys4_i),
    .tick_rtc_i  (tick_rtc_i),
    .tick_osc_i  (tick_osc_i),
    .tick_o      (tick_w)
  );

  wdg_clear_ctl u_clr (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .en_i      (wdg_en_i),
    .dual_i    (dual_clr_i),
    .clr_a_i   (clr_a_i),
    .clr_b_i   (clr_b_i),
    .clr_now_o (clr_now_w)
  );

  wdg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .en_i      (wdg_en_i),
    .tick_i    (tick_w),
    .clr_i     (clr_now_w),
    .timeout_o (timeout_o)
  );

  // R2: the "none" code produces no tick whatever the lines do
  a_r2_none_silent: assert property (@(posedge clk_i) disable iff (rst_i)
    (src_sel_i == SRC_NONE) |-> !tick_w);
  // R5: single mode clears on any strobe
  a_r5_single_clear: assert property (@(posedge clk_i) disable iff (rst_i)
    (wdg_en_i && !dual_clr_i && (clr_a_i || clr_b_i)) |-> clr_now_w);
endmodule

// File: tb/wdg_timer_tb_top.sv
module wdg_timer_tb_top;
  localparam int CLK_P = 10;
  localparam int W     = 4;
  localparam int PER   = 1 << W;

  logic clk = 1'b0;
  logic rst, en, dual;
  logic [1:0] src;
  logic [2:0] lines;
  logic ca, cb, to;

  int n_chk = 0, n_bad = 0, pulses = 0;
  logic [2:0] cur_mask;

  always #(CLK_P/2) clk = ~clk;

  wdg_timer #(.CNT_W(W)) dut_i (
    .clk_i(clk), .rst_i(rst), .wdg_en_i(en), .dual_clr_i(dual),
    .src_sel_i(src), .tick_sys4_i(lines[0]), .tick_rtc_i(lines[1]),
    .tick_osc_i(lines[2]), .clr_a_i(ca), .clr_b_i(cb), .timeout_o(to));

  // vector fields: [16] en, [15:14] src, [13:12] line code (3 = all), [11:4] ticks, [3:0] pulses
  localparam logic [16:0] VEC [8] = '{
    {1'b1, 2'd0, 2'd0, 8'd16, 4'd1},
    {1'b1, 2'd0, 2'd0, 8'd15, 4'd0},
    {1'b1, 2'd1, 2'd1, 8'd32, 4'd2},
    {1'b1, 2'd2, 2'd2, 8'd48, 4'd3},
    {1'b1, 2'd0, 2'd1, 8'd40, 4'd0},
    {1'b1, 2'd3, 2'd3, 8'd40, 4'd0},
    {1'b0, 2'd0, 2'd3, 8'd40, 4'd0},
    {1'b1, 2'd2, 2'd3, 8'd17, 4'd1}
  };
  localparam string VREQ [8] = '{"R3", "R1", "R3", "R3", "R2", "R2", "R4", "R2"};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic e, input logic d, input logic [1:0] s);
    en = e; dual = d; src = s; lines = '0; ca = 0; cb = 0; rst = 1;
    repeat (2) @(posedge clk);
    #1 rst = 0; pulses = 0;
  endtask

  task automatic step(input logic [2:0] l, input logic a, input logic b);
    lines = l; ca = a; cb = b;
    @(posedge clk);
    #1;
    lines = '0; ca = 0; cb = 0;
    pulses += int'(to);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(cur_mask, 1'b0, 1'b0);
  endtask

  function automatic logic [2:0] mask_of(input logic [1:0] code);
    return (code == 2'd3) ? 3'b111 : (3'b001 << code);
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    // R1: reset state
    do_reset(1'b1, 1'b0, 2'd0);
    chk("R1 reset output", int'(to), 0);

    for (int v = 0; v < 8; v++) begin
      do_reset(VEC[v][16], 1'b0, VEC[v][15:14]);
      cur_mask = mask_of(VEC[v][13:12]);
      ticks(int'(VEC[v][11:4]));
      chk(VREQ[v], pulses, int'(VEC[v][3:0]));
    end

    cur_mask = 3'b001;
    // R3: single-cycle pulse
    do_reset(1'b1, 1'b0, 2'd0);
    ticks(PER);
    chk("R3 pulse high", int'(to), 1);
    step(3'b000, 0, 0);
    chk("R3 pulse drops", int'(to), 0);

    // R5: single mode, strobe A then strobe B each clear
    do_reset(1'b1, 1'b0, 2'd0);
    ticks(12); step(3'b000, 1, 0); ticks(12); step(3'b000, 0, 1);
    ticks(PER - 1);
    chk("R5 no pulse after clears", pulses, 0);
    ticks(1);
    chk("R5 pulse one period after clear", pulses, 1);

    // R6: lone strobe in paired mode does not clear
    do_reset(1'b1, 1'b1, 2'd0);
    ticks(12); step(3'b000, 1, 0); ticks(12);
    chk("R6 lone strobe ignored", pulses, 1);

    // R6: B then A clears
    do_reset(1'b1, 1'b1, 2'd0);
    ticks(10); step(3'b000, 0, 1); ticks(3); step(3'b000, 1, 0);
    ticks(PER - 1);
    chk("R6 B-then-A clears", pulses, 0);
    ticks(1);
    chk("R6 period after pair", pulses, 1);

    // R6: both in one cycle
    do_reset(1'b1, 1'b1, 2'd0);
    ticks(10); step(3'b000, 1, 1); ticks(PER - 1);
    chk("R6 same-cycle pair clears", pulses, 0);

    // R7: repeated same strobe adds nothing
    do_reset(1'b1, 1'b1, 2'd0);
    ticks(10); step(3'b000, 1, 0); step(3'b000, 1, 0); step(3'b000, 1, 0); ticks(6);
    chk("R7 repeated strobe no clear", pulses, 1);

    // R7: marks drop after a clear
    do_reset(1'b1, 1'b1, 2'd0);
    ticks(5); step(3'b000, 1, 0); step(3'b000, 0, 1);
    ticks(5); step(3'b000, 0, 1); ticks(PER - 5);
    chk("R7 marks dropped after clear", pulses, 1);

    // R8: clear beats simultaneous tick
    do_reset(1'b1, 1'b0, 2'd0);
    ticks(10); step(3'b001, 1, 0); ticks(PER - 1);
    chk("R8 tick lost to clear", pulses, 0);
    ticks(1);
    chk("R8 period after clear", pulses, 1);

    // R9: reset drops a pending mark
    do_reset(1'b1, 1'b1, 2'd0);
    ticks(10); step(3'b000, 1, 0);
    do_reset(1'b1, 1'b1, 2'd0);
    ticks(10); step(3'b000, 0, 1); ticks(PER - 10);
    chk("R9 mark cleared by reset", pulses, 1);

    finish_run();
  end
endmodule